// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block is the digital back end of a pipelined analog-to-digital converter with a chain of residue stages, ten by default. Every stage resolves its share of a sample and reports a 2-bit decision. Each stage amplifies its residue by two, so a stage carries one effective bit and one redundant bit. Stage k resolves a given sample k time slots after stage 0 does. The block therefore delays each stage's decision so that all decisions for one sample meet. It then adds the aligned decisions with binary weights into a single offset-binary word. Because of the redundancy, small comparator errors in one stage are absorbed by the stages that follow.

The block runs on the slot clock, which is twice the sample rate, so the opposite-phase stages map onto successive slots. A strobe marks each slot in which the stage decisions are live. Only marked slots move the delay lines. The corrected word leaves through a register with a valid flag. That flag stays low until the delay lines hold a complete sample after reset.

Top module: `adc_err_corr`

## Requirements
- R1: While reset is high and on the first sampling after it, `out_word_o` is 0 and `out_vld_o` is 0.
- R2: The stage decisions arrive packed in `codes_i`, with stage k in bits [2k+1:2k]. Stage 0 carries weight 2^(N-1) and stage k carries weight 2^(N-1-k). The output word is the sum of each decision times its weight, read as offset binary, so all-zero decisions give 0.
- R3: A decision of 2'b11 counts as 2'b10.
- R4: A weighted sum above 2^N-1 is saturated to 2^N-1 (all ones). It does not wrap.
- R5: A sample's stage-k decision is presented k accepted slots after its stage-0 decision. The corrected word for that sample appears after the clock edge that ends the accepted slot in which its last-stage decision was presented.
- R6: After reset, `out_vld_o` stays low for the first N-1 accepted slots. It rises after the N-th accepted slot.
- R7: A slot with `in_vld_i` low is ignored. The stage decisions in that slot do not enter the delay lines, `out_word_o` holds its value, and `out_vld_o` is 0 after that edge.
- R8: Different decision sets with the same weighted sum, such as a 1 followed by a 0 versus a 0 followed by a 2, produce the same word.
- R9: Pure binary decisions (each stage 0 or 1) reproduce the binary value they spell, for every N-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| in_vld_i | input | 1 | Marks a slot whose stage decisions are live |
| codes_i | input | 2*NUM_STG | Stage decisions, stage k at bits [2k+1:2k] |
| out_word_o | output | NUM_STG | Corrected offset-binary word |
| out_vld_o | output | 1 | High when `out_word_o` holds a new corrected sample |

## Verification
Every 10-bit value is sent once as pure binary decisions. This checks that each stage lines up with the right weight. Every value is sent again in a redundant form, where one 1-then-0 pair is rewritten as 0-then-2. Matching words in both runs separate true carry addition from bit concatenation. Further samples cover the corners:
- all-2 and all-3 decisions, which must saturate;
- a lone 2 or 3 in the first stage, which overflows by exactly one;
- a 3 in the last stage only, which must clamp to 2;
- random decisions.

Idle slots filled with random data are spread through the stream, to show that such slots neither shift the alignment nor disturb the word.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int unsigned CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_TOP = 2'b10;

    function automatic code_t clamp_code(input code_t raw);
        return (raw > CODE_TOP) ? CODE_TOP : raw;
    endfunction

endpackage

// File: rtl/corr_code_clamp.sv
module corr_code_clamp
    import adc_corr_pkg::*;
(
    input  code_t raw_i,
    output code_t legal_o
);

    always_comb begin
        legal_o = clamp_code(raw_i);
    end

endmodule

// File: rtl/corr_align_dly.sv
module corr_align_dly #(
    parameter int unsigned DEPTH = 1,
    parameter int unsigned W     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout_o = din_i;
        end else begin : g_line
            logic [W-1:0] tap_q [DEPTH];
            logic [W-1:0] tap_d [DEPTH];

            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    tap_d[i] = tap_q[i];
                end
                if (en_i) begin
                    tap_d[0] = din_i;
                    for (int i = 1; i < DEPTH; i++) begin
                        tap_d[i] = tap_q[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (rst) tap_q[i] <= '0;
                    else     tap_q[i] <= tap_d[i];
                end
            end

            assign dout_o = tap_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/corr_sum_sat.sv
module corr_sum_sat #(
    parameter int unsigned NUM_STG = 10
) (
    input  logic [2*NUM_STG-1:0] aligned_i,
    output logic [NUM_STG-1:0]   word_o
);

    localparam int unsigned ACC_W = NUM_STG + 1;

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NUM_STG; k++) begin
            acc = acc + (ACC_W'(aligned_i[2*k +: 2]) << (NUM_STG - 1 - k));
        end
        word_o = acc[ACC_W-1] ? {NUM_STG{1'b1}} : acc[NUM_STG-1:0];
    end

endmodule

// File: rtl/adc_err_corr.sv
module adc_err_corr
    import adc_corr_pkg::*;
#(
    parameter int unsigned NUM_STG = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld_i,
    input  logic [2*NUM_STG-1:0] codes_i,
    output logic [NUM_STG-1:0]   out_word_o,
    output logic                 out_vld_o
);

    localparam int unsigned FILL_W   = $clog2(NUM_STG);
    localparam int unsigned FILL_TOP = NUM_STG - 1;

    typedef struct packed {
        logic [FILL_W-1:0]  fill;
        logic               vld;
        logic [NUM_STG-1:0] word;
    } state_t;

    state_t st_q, st_d;

    logic [2*NUM_STG-1:0] legal;
    logic [2*NUM_STG-1:0] aligned;
    logic [NUM_STG-1:0]   corr_word;

    generate
        for (genvar k = 0; k < NUM_STG; k++) begin : g_stage
            corr_code_clamp u_clamp (
                .raw_i   (codes_i[2*k +: 2]),
                .legal_o (legal[2*k +: 2])
            );

            corr_align_dly #(
                .DEPTH (NUM_STG - 1 - k),
                .W     (CODE_W)
            ) u_dly (
                .clk    (clk),
                .rst    (rst),
                .en_i   (in_vld_i),
                .din_i  (legal[2*k +: 2]),
                .dout_o (aligned[2*k +: 2])
            );
        end
    endgenerate

    corr_sum_sat #(
        .NUM_STG (NUM_STG)
    ) u_sum (
        .aligned_i (aligned),
        .word_o    (corr_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_vld_i) begin
            st_d.word = corr_word;
            st_d.vld  = (st_q.fill == FILL_W'(FILL_TOP));
            if (st_q.fill != FILL_W'(FILL_TOP)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_word_o = st_q.word;
    assign out_vld_o  = st_q.vld;

endmodule

// File: rtl/adc_err_corr_chk.sv
module adc_err_corr_chk #(
    parameter int unsigned NUM_STG = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               in_vld_i,
    input logic [NUM_STG-1:0] out_word_o,
    input logic               out_vld_o
);

    localparam int unsigned CNT_W = $clog2(NUM_STG + 1);

    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (in_vld_i && seen_q != CNT_W'(NUM_STG))
            seen_q <= seen_q + 1'b1;
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (out_word_o == '0 && !out_vld_o));

    // R6
    early_vld_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> seen_q == CNT_W'(NUM_STG));

    // R6
    fill_done_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && seen_q >= CNT_W'(NUM_STG - 1)) |=> out_vld_o);

    // R7
    idle_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !out_vld_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> $stable(out_word_o));

endmodule

bind adc_err_corr adc_err_corr_chk #(
    .NUM_STG (NUM_STG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_vld_i   (in_vld_i),
    .out_word_o (out_word_o),
    .out_vld_o  (out_vld_o)
);

// File: tb/adc_err_corr_test.sv
module adc_err_corr_test;

    localparam int N      = 10;
    localparam int PERIOD = 10;
    localparam int NSPEC  = 8;
    localparam int NRAND  = 256;
    localparam int NS     = 2 * (1 << N) + NSPEC + NRAND;
    localparam int TOPV   = (1 << N) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_vld_i = 1'b0;
    logic [2*N-1:0]   codes_i = '0;
    logic [N-1:0]     out_word_o;
    logic             out_vld_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [2*N-1:0] samp [NS];
    string          tag  [NS];

    always #(PERIOD/2) clk = ~clk;

    adc_err_corr #(.NUM_STG(N)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_vld_i   (in_vld_i),
        .codes_i    (codes_i),
        .out_word_o (out_word_o),
        .out_vld_o  (out_vld_o)
    );

    function automatic logic [N-1:0] expect_word(input logic [2*N-1:0] c);
        int sum = 0;
        for (int k = 0; k < N; k++) begin
            int v = int'(c[2*k +: 2]);
            if (v == 3) v = 2;
            sum += v << (N - 1 - k);
        end
        if (sum > TOPV) sum = TOPV;
        return N'(sum);
    endfunction

    function automatic logic [2*N-1:0] binary_codes(input int v);
        logic [2*N-1:0] c = '0;
        for (int k = 0; k < N; k++) c[2*k +: 2] = {1'b0, v[N-1-k]};
        return c;
    endfunction

    function automatic logic [2*N-1:0] redundant_codes(input int v);
        logic [2*N-1:0] c = binary_codes(v);
        for (int k = 0; k < N - 1; k++) begin
            if (c[2*k +: 2] == 2'd1 && c[2*(k+1) +: 2] == 2'd0) begin
                c[2*k +: 2]     = 2'd0;
                c[2*(k+1) +: 2] = 2'd2;
                return c;
            end
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act_w, input logic [N-1:0] exp_w,
                         input logic act_v, input logic exp_v);
        n_chk++;
        if (act_w !== exp_w || act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: word=%0d vld=%0b expected word=%0d vld=%0b",
                     req, act_w, act_v, exp_w, exp_v);
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] last_w;
        for (int v = 0; v <= TOPV; v++) begin
            samp[v] = binary_codes(v);              tag[v] = "R9";
            samp[TOPV + 1 + v] = redundant_codes(v); tag[TOPV + 1 + v] = "R8";
        end
        begin
            int b = 2 * (1 << N);
            samp[b+0] = {N{2'b10}};                 tag[b+0] = "R4";
            samp[b+1] = {N{2'b11}};                 tag[b+1] = "R3";
            samp[b+2] = {2'b11, {(N-1){2'b00}}};    tag[b+2] = "R3";
            samp[b+3] = 20'(2'b10);                 tag[b+3] = "R4";
            samp[b+4] = 20'(2'b11);                 tag[b+4] = "R4";
            samp[b+5] = '0;                         tag[b+5] = "R2";
            samp[b+6] = {{(N-1){2'b10}}, 2'b01};    tag[b+6] = "R4";
            samp[b+7] = {{(N-1){2'b00}}, 2'b01};    tag[b+7] = "R2";
            for (int r = 0; r < NRAND; r++) begin
                samp[b + NSPEC + r] = 20'($urandom);
                tag[b + NSPEC + r]  = "R5";
            end
        end

        repeat (3) @(negedge clk);
        check("R1", out_word_o, '0, out_vld_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", out_word_o, '0, out_vld_o, 1'b0);

        last_w = '0;
        for (int t = 0; t < NS + N - 1; t++) begin
            if (t % 37 == 5) begin
                in_vld_i = 1'b0;
                codes_i  = 20'($urandom);
                @(posedge clk);
                @(negedge clk);
                check("R7", out_word_o, last_w, out_vld_o, 1'b0);
            end
            in_vld_i = 1'b1;
            for (int k = 0; k < N; k++) begin
                int s = t - k;
                codes_i[2*k +: 2] = (s >= 0 && s < NS) ? samp[s][2*k +: 2] : 2'b00;
            end
            @(posedge clk);
            @(negedge clk);
            if (t < N - 1) begin
                check("R6", out_vld_o ? out_word_o : '0, '0, out_vld_o, 1'b0);
            end else begin
                int s = t - (N - 1);
                logic [N-1:0] e = expect_word(samp[s]);
                check(t == N - 1 ? "R6" : tag[s], out_word_o, e, out_vld_o, 1'b1);
                last_w = e;
            end
        end
        in_vld_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", out_word_o, last_w, out_vld_o, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule